// File: doc/BRIEF.md
# Interline CCD Vertical Transfer Sequencer

This block drives the vertical shift register of an interline CCD. It produces four-phase vertical clocks as digital level codes for external analog drivers. Phase 1 takes one of three levels: low, mid, or a transfer-high level. Phases 2, 3 and 4 are two-level. A separate set of phase 2/3/4 codes goes to the bottom half of the array.

A frame start runs the charge transfer from the photodiodes into the vertical registers:
- a leading pedestal,
- the phase-1 high pulse,
- a trailing pedestal, during which phase 4 rises at the moment phase 1 drops from high to mid,
- a settle delay.

After that, each accepted line request makes one four-step row shift, or two when binning by two is selected. A one-cycle strobe marks the end of each request. The frame length in row shifts depends on the readout split. When the top and bottom halves are read out separately, the bottom-half phase order is mirrored so that the halves shift apart. The readout split and the binning choice are latched only when a frame start is accepted. All durations are parameters counted in clock cycles.

Top module: `vxfer_seq`

## Requirements
- R1: After reset the outputs are as follows. `v1_code` is mid. The level codes are low = 2'b00, mid = 2'b01 and high = 2'b10. `ph_top` and `ph_bot` are both 3'b001; bit 0 is phase 2, bit 1 is phase 3 and bit 2 is phase 4. `row_done`, `frame_done` and `line_ready` are all 0.
- R2: `frame_start` is accepted when the block is idle, ready or done. Once accepted, phase 1 stays at mid (the leading pedestal). It shows high exactly LEAD_CYC+1 cycles after the sampling edge and holds high for exactly XFER_CYC cycles. High is only ever entered from mid.
- R3: Phase 1 leaves high in a defined way. In the same cycle it returns to mid, phase 4 rises. The pattern (mid, 3'b101) then holds for exactly TRAIL_CYC cycles.
- R4: After the trailing pedestal, the rest pattern (mid, 3'b001) is shown. `line_ready` rises exactly LEAD_CYC+XFER_CYC+TRAIL_CYC+DELAY_CYC+1 cycles after the `frame_start` sampling edge.
- R5: A `line_req` sampled while ready starts one row shift of four steps, each exactly STEP_CYC cycles long. The steps are (low, 3'b011), (low, 3'b110), (mid, 3'b100) and (mid, 3'b001). `row_done` pulses for one cycle right after the fourth step. `line_ready` drops while the shift runs.
- R6: With binning enabled (`bin2` = 1 at frame start), each request runs two complete row shifts back to back and gives a single `row_done` pulse.
- R7: A frame has FULL_LINES row shifts in modes 2'b00 (single) and 2'b01 (dual left/right). It has HALF_LINES row shifts in modes 2'b10 (dual top/bottom) and 2'b11 (quad). `frame_done` rises together with the last `row_done`. It stays high, with `line_ready` low, until the next frame start.
- R8: In modes 2'b10 and 2'b11, `ph_bot` equals `ph_top` with bits 0 and 2 swapped. In the other modes `ph_bot` equals `ph_top`.
- R9: The following inputs have no effect on the outputs:
  - a `line_req` outside the ready state;
  - a `frame_start` during the transfer or a shift;
  - a change of `mode` or `bin2` in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to begin a frame (photodiode transfer) |
| mode | input | 2 | Readout split: 00 single, 01 dual left/right, 10 dual top/bottom, 11 quad |
| bin2 | input | 1 | Vertical binning by two |
| line_req | input | 1 | Request one line's vertical shift |
| line_ready | output | 1 | A line request will be accepted |
| v1_code | output | 2 | Phase-1 level code (low/mid/high) |
| ph_top | output | 3 | Top-half phases 2..4 (bit 0 = phase 2) |
| ph_bot | output | 3 | Bottom-half phases 2..4 (bit 0 = phase 2) |
| row_done | output | 1 | One-cycle strobe at the end of each line request |
| frame_done | output | 1 | All row shifts of the frame are done |

## Verification
A wrong step counter or state shows up at the ports within one step time, because every step has a fixed pattern and a fixed length. The observed run of patterns is compared segment by segment with the expected run. A corrupted row counter shows up only at the end of a frame: `frame_done` rises early or late compared with the count of `row_done` pulses. A wrong mirror selection affects `ph_bot` from the first pattern change of the frame. Accept-window faults show up as extra segments when requests or frame starts are driven at times when they must be ignored.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

  typedef enum logic [1:0] {
    V1_LOW  = 2'b00,
    V1_MID  = 2'b01,
    V1_HIGH = 2'b10
  } v1_lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_DELAY,
    ST_READY,
    ST_SHIFT,
    ST_DONE
  } vstate_e;

  localparam int NSTEP = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // {phase1 code, phase4, phase3, phase2} for a state and shift step
  function automatic logic [4:0] phase_word(input vstate_e s, input logic [1:0] k);
    logic [4:0] w;
    w = {V1_MID, 3'b001};
    case (s)
      ST_XFER:  w = {V1_HIGH, 3'b001};
      ST_TRAIL: w = {V1_MID, 3'b101};
      ST_SHIFT: begin
        case (k)
          2'd0:    w = {V1_LOW, 3'b011};
          2'd1:    w = {V1_LOW, 3'b110};
          2'd2:    w = {V1_MID, 3'b100};
          default: w = {V1_MID, 3'b001};
        endcase
      end
      default:  w = {V1_MID, 3'b001};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/vxfer_timer.sv
module vxfer_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/vxfer_phase_map.sv
module vxfer_phase_map #(
  parameter int NPH = 3
) (
  input  logic           mirror,
  input  logic [NPH-1:0] top_in,
  output logic [NPH-1:0] bot_out
);

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign bot_out[i] = mirror ? top_in[NPH-1-i] : top_in[i];
  end

endmodule

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
  import vxfer_pkg::*;
#(
  parameter int LEAD_CYC   = 1600,
  parameter int XFER_CYC   = 1600,
  parameter int TRAIL_CYC  = 1600,
  parameter int DELAY_CYC  = 400,
  parameter int STEP_CYC   = 1000,
  parameter int FULL_LINES = 4920,
  parameter int HALF_LINES = 2460,
  parameter int TW         = 11,
  parameter int LW         = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] mode,
  input  logic       bin2,
  input  logic       line_req,
  output logic [1:0] nx_v1,
  output logic [2:0] nx_ph,
  output logic       nx_mirror,
  output logic       nx_row_done,
  output logic       nx_ready,
  output logic       nx_done
);

  vstate_e       st, st_d;
  logic [1:0]    step, step_d;
  logic          pass, pass_d;
  logic [LW-1:0] rows, rows_d;
  logic [1:0]    mode_q, mode_d;
  logic          bin_q, bin_d;
  logic          ld;
  logic [TW-1:0] ld_val;
  logic          tzero;
  logic          fin;
  logic [4:0]    word_d;

  vxfer_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tzero)
  );

  always_comb begin
    st_d   = st;
    step_d = step;
    pass_d = pass;
    rows_d = rows;
    mode_d = mode_q;
    bin_d  = bin_q;
    ld     = 1'b0;
    ld_val = '0;
    fin    = 1'b0;
    case (st)
      ST_IDLE, ST_READY, ST_DONE: begin
        if (frame_start) begin
          st_d   = ST_LEAD;
          ld     = 1'b1;
          ld_val = TW'(LEAD_CYC - 1);
          mode_d = mode;
          bin_d  = bin2;
          rows_d = mode[1] ? LW'(HALF_LINES) : LW'(FULL_LINES);
        end else if (st == ST_READY && line_req) begin
          st_d   = ST_SHIFT;
          step_d = 2'd0;
          pass_d = 1'b0;
          ld     = 1'b1;
          ld_val = TW'(STEP_CYC - 1);
        end
      end
      ST_LEAD: if (tzero) begin
        st_d   = ST_XFER;
        ld     = 1'b1;
        ld_val = TW'(XFER_CYC - 1);
      end
      ST_XFER: if (tzero) begin
        st_d   = ST_TRAIL;
        ld     = 1'b1;
        ld_val = TW'(TRAIL_CYC - 1);
      end
      ST_TRAIL: if (tzero) begin
        st_d   = ST_DELAY;
        ld     = 1'b1;
        ld_val = TW'(DELAY_CYC - 1);
      end
      ST_DELAY: if (tzero) begin
        st_d = ST_READY;
      end
      ST_SHIFT: if (tzero) begin
        if (step == 2'(NSTEP - 1)) begin
          rows_d = rows - 1'b1;
          if (bin_q && !pass) begin
            step_d = 2'd0;
            pass_d = 1'b1;
            ld     = 1'b1;
            ld_val = TW'(STEP_CYC - 1);
          end else begin
            fin  = 1'b1;
            st_d = (rows == LW'(1)) ? ST_DONE : ST_READY;
          end
        end else begin
          step_d = step + 1'b1;
          ld     = 1'b1;
          ld_val = TW'(STEP_CYC - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      step   <= 2'd0;
      pass   <= 1'b0;
      rows   <= '0;
      mode_q <= 2'b00;
      bin_q  <= 1'b0;
    end else begin
      st     <= st_d;
      step   <= step_d;
      pass   <= pass_d;
      rows   <= rows_d;
      mode_q <= mode_d;
      bin_q  <= bin_d;
    end
  end

  // next-value decode: the top registers these so outputs track the state
  assign word_d      = phase_word(st_d, step_d);
  assign nx_v1       = word_d[4:3];
  assign nx_ph       = word_d[2:0];
  assign nx_mirror   = mode_d[1];
  assign nx_row_done = fin;
  assign nx_ready    = (st_d == ST_READY);
  assign nx_done     = (st_d == ST_DONE);

  // R7: a ready state always has rows left to shift
  a_r7_rows_left: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READY) |-> (rows != '0));

  // R6: the second pass only exists with binning latched
  a_r6_pass_needs_bin: assert property (@(posedge clk) disable iff (rst)
    pass |-> bin_q);

  // R9: latched mode holds while a frame is in progress
  a_r9_mode_stable: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIFT || st == ST_XFER || st == ST_TRAIL) |-> $stable(mode_q));

endmodule

// File: rtl/vxfer_seq.sv
module vxfer_seq
  import vxfer_pkg::*;
#(
  parameter int LEAD_CYC   = 1600,
  parameter int XFER_CYC   = 1600,
  parameter int TRAIL_CYC  = 1600,
  parameter int DELAY_CYC  = 400,
  parameter int STEP_CYC   = 1000,
  parameter int FULL_LINES = 4920,
  parameter int HALF_LINES = 2460
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] mode,
  input  logic       bin2,
  input  logic       line_req,
  output logic       line_ready,
  output logic [1:0] v1_code,
  output logic [2:0] ph_top,
  output logic [2:0] ph_bot,
  output logic       row_done,
  output logic       frame_done
);

  localparam int TMAX = imax(imax(imax(LEAD_CYC, XFER_CYC), imax(TRAIL_CYC, DELAY_CYC)), STEP_CYC);
  localparam int TW   = imax($clog2(TMAX + 1), 1);
  localparam int LW   = imax($clog2(FULL_LINES + 1), 1);

  logic [1:0] nx_v1;
  logic [2:0] nx_ph, nx_bot;
  logic       nx_mirror, nx_row_done, nx_ready, nx_done;
  logic       mirror_q;

  vxfer_ctrl #(
    .LEAD_CYC   (LEAD_CYC),
    .XFER_CYC   (XFER_CYC),
    .TRAIL_CYC  (TRAIL_CYC),
    .DELAY_CYC  (DELAY_CYC),
    .STEP_CYC   (STEP_CYC),
    .FULL_LINES (FULL_LINES),
    .HALF_LINES (HALF_LINES),
    .TW         (TW),
    .LW         (LW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .mode        (mode),
    .bin2        (bin2),
    .line_req    (line_req),
    .nx_v1       (nx_v1),
    .nx_ph       (nx_ph),
    .nx_mirror   (nx_mirror),
    .nx_row_done (nx_row_done),
    .nx_ready    (nx_ready),
    .nx_done     (nx_done)
  );

  vxfer_phase_map #(.NPH(3)) u_map (
    .mirror  (nx_mirror),
    .top_in  (nx_ph),
    .bot_out (nx_bot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_code    <= V1_MID;
      ph_top     <= 3'b001;
      ph_bot     <= 3'b001;
      mirror_q   <= 1'b0;
      row_done   <= 1'b0;
      line_ready <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      v1_code    <= nx_v1;
      ph_top     <= nx_ph;
      ph_bot     <= nx_bot;
      mirror_q   <= nx_mirror;
      row_done   <= nx_row_done;
      line_ready <= nx_ready;
      frame_done <= nx_done;
    end
  end

  // R2: transfer-high is only entered from mid
  a_r2_high_from_mid: assert property (@(posedge clk) disable iff (rst)
    (v1_code == V1_HIGH && $past(v1_code) != V1_HIGH) |-> ($past(v1_code) == V1_MID));

  // R3: leaving high lands on mid with phase 4 rising in the same cycle
  a_r3_p4_rises_on_exit: assert property (@(posedge clk) disable iff (rst)
    (v1_code != V1_HIGH && $past(v1_code) == V1_HIGH) |-> (v1_code == V1_MID && $rose(ph_top[2])));

  // R5: low never jumps straight to high
  a_r5_low_not_high: assert property (@(posedge clk) disable iff (rst)
    (v1_code == V1_LOW) |=> (v1_code != V1_HIGH));

  // R5: row_done is a single-cycle strobe
  a_r5_done_strobe: assert property (@(posedge clk) disable iff (rst)
    row_done |=> !row_done);

  // R7: done and ready never coexist
  a_r7_done_not_ready: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && line_ready));

  // R8: bottom-half ordering against top half
  a_r8_bottom_order: assert property (@(posedge clk) disable iff (rst)
    mirror_q |-> (ph_bot == {ph_top[0], ph_top[1], ph_top[2]}));

  a_r8_bottom_same: assert property (@(posedge clk) disable iff (rst)
    !mirror_q |-> (ph_bot == ph_top));

endmodule

// File: tb/vxfer_seq_tb.sv
module vxfer_seq_tb_top;

  localparam int LEAD  = 5;
  localparam int XFER  = 4;
  localparam int TRAIL = 6;
  localparam int DLY   = 3;
  localparam int STEP  = 3;
  localparam int FULL  = 8;
  localparam int HALF  = 4;

  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_MID  = 2'b01;
  localparam logic [1:0] LV_HIGH = 2'b10;
  localparam logic [15:0] DC     = 16'h0000;
  localparam logic [15:0] EOF_DC = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic bin2 = 1'b0;
  logic line_req = 1'b0;
  logic line_ready, row_done, frame_done;
  logic [1:0] v1_code;
  logic [2:0] ph_top, ph_bot;

  int n_chk = 0;
  int n_fail = 0;
  int n_rowdone = 0;
  bit finished = 0;

  logic [23:0] exp_q[$];

  always #5 clk = ~clk;

  vxfer_seq #(
    .LEAD_CYC (LEAD), .XFER_CYC (XFER), .TRAIL_CYC (TRAIL), .DELAY_CYC (DLY),
    .STEP_CYC (STEP), .FULL_LINES (FULL), .HALF_LINES (HALF)
  ) dut_i (
    .clk (clk), .rst (rst), .frame_start (frame_start), .mode (mode), .bin2 (bin2),
    .line_req (line_req), .line_ready (line_ready), .v1_code (v1_code),
    .ph_top (ph_top), .ph_bot (ph_bot), .row_done (row_done), .frame_done (frame_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] bot_of(input logic m, input logic [2:0] t);
    return m ? {t[0], t[1], t[2]} : t;
  endfunction

  function automatic logic [23:0] item(input logic [1:0] v, input logic [2:0] t, input logic m,
                                       input logic [15:0] len);
    return {v, t, bot_of(m, t), len};
  endfunction

  // driver side: expected segments of one frame
  task automatic push_frame(input logic [1:0] md, input logic bn, input int reqs);
    logic m;
    m = md[1];
    exp_q.push_back(item(LV_HIGH, 3'b001, m, 16'(XFER)));   // R2
    exp_q.push_back(item(LV_MID,  3'b101, m, 16'(TRAIL)));  // R3
    exp_q.push_back(item(LV_MID,  3'b001, m, DC));          // R4
    for (int r = 0; r < reqs; r++) begin
      for (int p = 0; p < (bn ? 2 : 1); p++) begin           // R5 R6
        exp_q.push_back(item(LV_LOW, 3'b011, m, 16'(STEP)));
        exp_q.push_back(item(LV_LOW, 3'b110, m, 16'(STEP)));
        exp_q.push_back(item(LV_MID, 3'b100, m, 16'(STEP)));
        if (bn && p == 0) exp_q.push_back(item(LV_MID, 3'b001, m, 16'(STEP)));
      end
      exp_q.push_back(item(LV_MID, 3'b001, m, (r == reqs - 1) ? EOF_DC : DC));
    end
  endtask

  // monitor: segment scoreboard and row_done counter
  initial begin
    logic [7:0]  cur;
    logic [7:0]  t;
    logic [23:0] e;
    int          len;
    bit          armed;
    cur = 8'h00; len = 0; armed = 0;
    @(negedge clk);
    while (rst) @(negedge clk);
    cur = {v1_code, ph_top, ph_bot};
    len = 1;
    forever begin
      @(negedge clk);
      if (row_done) n_rowdone++;
      t = {v1_code, ph_top, ph_bot};
      if (t == cur) begin
        len++;
      end else begin
        if (armed) begin
          if (exp_q.size() == 0) begin
            chk("R5 unexpected segment", {24'h0, cur}, 32'h0);
            armed = 0;
          end else begin
            e = exp_q.pop_front();
            chk("R2/R3/R5/R6/R8 segment pattern", {24'h0, cur}, {24'h0, e[23:16]});
            if (e[15:0] != DC && e[15:0] != EOF_DC)
              chk("R2/R3/R5 segment length", 32'(len), {16'h0, e[15:0]});
            if (e[15:0] == EOF_DC) armed = 0;
          end
        end
        cur = t;
        len = 1;
        if (t[7:6] == LV_HIGH) armed = 1;
      end
    end
  end

  task automatic run_frame(input logic [1:0] md, input logic bn, input int reqs, input bit stress);
    int cnt, hi_at, rdy_at, rd0;
    push_frame(md, bn, reqs);
    rd0 = n_rowdone;
    @(negedge clk);
    mode = md; bin2 = bn; frame_start = 1'b1;
    cnt = 0; hi_at = -1; rdy_at = -1;
    while (rdy_at < 0 && cnt < 200) begin
      @(negedge clk);
      frame_start = 1'b0;
      cnt++;
      if (stress) begin
        mode = ~md; bin2 = ~bn;                  // R9 mid-frame change
        line_req = (cnt == 2);                   // R9 request before ready
        if (cnt == 4) frame_start = 1'b1;        // R9 start during transfer
      end
      if (hi_at < 0 && v1_code == LV_HIGH) hi_at = cnt;
      if (line_ready) rdy_at = cnt;
    end
    line_req = 1'b0;
    chk("R2 high pulse start", 32'(hi_at), 32'(LEAD + 1));
    chk("R4 ready rise", 32'(rdy_at), 32'(LEAD + XFER + TRAIL + DLY + 1));
    for (int r = 0; r < reqs; r++) begin
      while (!line_ready) @(negedge clk);
      line_req = 1'b1;
      @(negedge clk);
      line_req = 1'b0;
      chk("R5 ready drops in shift", {31'h0, line_ready}, 32'h0);
      if (stress && r == 1) begin                // R9 start during shift
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
      end
      if (stress && r == 2) begin                // R9 request during shift
        line_req = 1'b1;
        @(negedge clk);
        line_req = 1'b0;
      end
      while (!row_done && !frame_done) @(negedge clk);
    end
    while (!frame_done) @(negedge clk);
    chk("R7 done with last strobe", {31'h0, row_done}, 32'h1);
    chk("R7 row_done count", 32'(n_rowdone - rd0), 32'(reqs));
    repeat (4) @(negedge clk);
    chk("R7 done held", {31'h0, frame_done}, 32'h1);
    chk("R7 not ready when done", {31'h0, line_ready}, 32'h0);
    chk("R7 no extra strobes", 32'(n_rowdone - rd0), 32'(reqs));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 v1", {30'h0, v1_code}, {30'h0, LV_MID});
    chk("R1 top", {29'h0, ph_top}, 32'h1);
    chk("R1 bot", {29'h0, ph_bot}, 32'h1);
    chk("R1 flags", {29'h0, row_done, frame_done, line_ready}, 32'h0);
    // R9 request while idle is ignored
    line_req = 1'b1;
    @(negedge clk);
    line_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle request", {28'h0, v1_code, row_done, line_ready}, {28'h0, LV_MID, 2'b00});

    run_frame(2'b00, 1'b0, FULL, 1'b1);       // R7 single, R9 stress
    run_frame(2'b10, 1'b0, HALF, 1'b0);       // R7 R8 top/bottom
    run_frame(2'b11, 1'b1, HALF / 2, 1'b0);   // R6 R8 quad binned
    run_frame(2'b01, 1'b1, FULL / 2, 1'b1);   // R6 R7 left/right binned

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'h1);
    if (exp_q.size() == 1) chk("R7 final marker", {16'h0, exp_q[0][15:0]}, {16'h0, EOF_DC});
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule